// File: doc/BRIEF.md
# Performance Monitor Counter Bank

This block keeps the error tallies of a T1 line performance monitor together with their sticky status flags. An 8-bit tally counts CRC-6 errors. It advances whenever the low bit of an external CRC error counter changes state. A second 8-bit tally counts bipolar line code violations, which arrive as one-cycle pulses. A 4-bit tally counts framing errors, which also arrive as one-cycle pulses. A severely-errored-framing event flag rises whenever the low bit of an external event counter changes state.

When a tally rolls past its top value back to zero, it latches a saturation flag. That flag stays set until software clears it. Software clears each tally and its flag by driving the matching bit of an 8-bit control word from high to low. A high level or a rising edge on that bit does nothing. A low interrupt-enable bit in the same control word keeps the event flag at zero. The CRC tally is only meaningful while the line runs extended superframe framing, and the block reports this on a validity output. The status byte combines the four flags with externally supplied alarm bits, which pass through unchanged.

Top module: `pm_counter_bank`

## Requirements
- R1: `crc_count` increments by one at each clock edge where `crc_lsb_in` differs from its value at the previous edge. Both rising and falling changes count.
- R2: `bpv_count` increments by one at each clock edge where `bpv_pulse` is high.
- R3: `fe_count` is 4 bits wide and increments by one at each clock edge where `fe_pulse` is high.
- R4: Each tally wraps from its maximum value to 0. The wrap sets a sticky flag: status bit 2 for CRC, status bit 1 for bipolar violations and status bit 3 for framing errors. The flag stays set while counting continues.
- R5: Each tally and its flag clear when their control bit goes from 1 to 0. Bit 5 clears CRC, bit 4 clears bipolar violations and bit 6 clears framing errors. A steady level or a 0-to-1 change has no effect.
- R6: Status bit 4 sets when `sef_lsb_in` changes value. It clears when control bit 7 goes from 1 to 0.
- R7: While control bit 0 (interrupt enable) is 0, status bit 4 is held at 0, including when `sef_lsb_in` toggles. Raising bit 0 does not set the flag again.
- R8: If a count or set event and a clearing edge happen at the same clock edge, the clear wins: the tally and its flag become 0.
- R9: Status bits 7:5 equal `ext_stat` and status bit 0 equals `ais_in`. `crc_valid` equals `esf_mode` (1 = extended superframe).
- R10: Reset zeroes all tallies and flags. The first clock edge after reset only captures the inputs, so an input that differs from its value during reset is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| crc_lsb_in | input | 1 | Low bit of external CRC error counter |
| sef_lsb_in | input | 1 | Low bit of external severe framing event counter |
| bpv_pulse | input | 1 | One-cycle bipolar violation strobe |
| fe_pulse | input | 1 | One-cycle framing error strobe |
| ctrl_word | input | 8 | Control word: clear bits 7..4, interrupt enable bit 0 |
| esf_mode | input | 1 | 1 when extended superframe framing is received |
| ais_in | input | 1 | Alarm indication, passed to status bit 0 |
| ext_stat | input | 3 | External status, passed to status bits 7:5 |
| crc_count | output | 8 | CRC error tally |
| bpv_count | output | 8 | Bipolar violation tally |
| fe_count | output | 4 | Framing error tally |
| status | output | 8 | Status byte |
| crc_valid | output | 1 | CRC tally is meaningful |

## Verification
The bench targets two collisions: a counting event arriving at the same edge as the falling edge of its clear bit, and a wrap arriving at that same edge. It provokes them by driving a violation pulse or a CRC toggle in the same cycle that drops the control bit. This is done at an ordinary count and again with the bipolar tally parked at 255. The bench judges the result at the next sample: both the tally and its saturation flag must read zero. A third collision, an event-counter toggle in the cycle where bit 7 falls, must leave status bit 4 low.

// File: rtl/pm_pkg.sv
// Package: control word and status byte bit positions shared by the counter bank.
// Assumes an 8-bit control word and an 8-bit status byte.
package pm_pkg;
    localparam int CTRL_W      = 8;
    localparam int STAT_W      = 8;
    localparam int IRQ_EN_BIT  = 0;
    localparam int CLR_BPV_BIT = 4;
    localparam int CLR_CRC_BIT = 5;
    localparam int CLR_FE_BIT  = 6;
    localparam int CLR_SEF_BIT = 7;
    localparam int ST_AIS      = 0;
    localparam int ST_BPV_SAT  = 1;
    localparam int ST_CRC_SAT  = 2;
    localparam int ST_FE_SAT   = 3;
    localparam int ST_SEF_EVT  = 4;
    localparam int ST_EXT_LO   = 5;
endpackage

// File: rtl/pm_edge_det.sv
// Module: per-bit change and falling-edge detector against a registered copy.
// Assumes inputs are synchronous to clk. Outputs stay low until one sample
// has been taken after reset, so reset-time values never produce an event.
module pm_edge_det #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] toggle,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_q;
    logic         armed_q;

    // Keep the previous sample and note that a valid sample exists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            prev_q  <= din;
            armed_q <= 1'b1;
        end
    end

    // Compare the current value against the stored sample.
    always_comb begin
        toggle = armed_q ? (din ^ prev_q) : '0;
        fall   = armed_q ? (prev_q & ~din) : '0;
    end
endmodule

// File: rtl/pm_wrap_counter.sv
// Module: wrapping up-counter with a sticky saturation flag.
// Assumes inc and clr are single-cycle qualified events. A clear overrides an
// increment in the same cycle.
module pm_wrap_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count,
    output logic         sat
);
    localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

    // Advance, wrap and latch saturation; a clear takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            sat   <= 1'b0;
        end else if (clr) begin
            count <= '0;
            sat   <= 1'b0;
        end else if (inc) begin
            count <= count + 1'b1;
            if (count == MAX_VAL) begin
                sat <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pm_event_flag.sv
// Module: sticky event flag with an edge clear and a level hold-clear.
// Assumes set and clr are single-cycle events. hold_clr is a level. Any clear
// overrides a set in the same cycle.
module pm_event_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic hold_clr,
    output logic flag
);
    // Latch on set; drop on a clear edge or while held clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (clr || hold_clr) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end
    end
endmodule

// File: rtl/pm_counter_bank.sv
// Module: T1 performance monitor counter bank with sticky status flags.
// The CRC tally and the event flag count changes of external counter low bits.
// The violation and framing tallies count one-cycle pulses. Control bits 7..4
// clear on their falling edge. Control bit 0 low holds the event flag clear.
// Assumes all inputs are synchronous to clk.
module pm_counter_bank
    import pm_pkg::*;
#(
    parameter int CRC_W = 8,
    parameter int BPV_W = 8,
    parameter int FE_W  = 4,
    parameter int EXT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crc_lsb_in,
    input  logic              sef_lsb_in,
    input  logic              bpv_pulse,
    input  logic              fe_pulse,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              esf_mode,
    input  logic              ais_in,
    input  logic [EXT_W-1:0]  ext_stat,
    output logic [CRC_W-1:0]  crc_count,
    output logic [BPV_W-1:0]  bpv_count,
    output logic [FE_W-1:0]   fe_count,
    output logic [STAT_W-1:0] status,
    output logic              crc_valid
);
    localparam int N_TOG = 2;
    localparam int N_CLR = 4;

    logic [N_TOG-1:0] tog_in, tog_evt, tog_fall_nc;
    logic [N_CLR-1:0] clr_in, clr_tog_nc, clr_fall;
    logic             crc_sat, bpv_sat, fe_sat, sef_flag;
    logic             ctrl_unused;
    logic             tog_unused;

    assign tog_in      = {sef_lsb_in, crc_lsb_in};
    assign clr_in      = ctrl_word[CLR_SEF_BIT:CLR_BPV_BIT];
    assign ctrl_unused = ^ctrl_word[CLR_BPV_BIT-1:IRQ_EN_BIT+1];
    assign tog_unused  = ^{tog_fall_nc, clr_tog_nc};

    pm_edge_det #(.W(N_TOG)) u_tog_det (
        .clk(clk), .rst_n(rst_n), .din(tog_in),
        .toggle(tog_evt), .fall(tog_fall_nc)
    );

    pm_edge_det #(.W(N_CLR)) u_clr_det (
        .clk(clk), .rst_n(rst_n), .din(clr_in),
        .toggle(clr_tog_nc), .fall(clr_fall)
    );

    pm_wrap_counter #(.W(CRC_W)) u_crc_cnt (
        .clk(clk), .rst_n(rst_n), .inc(tog_evt[0]),
        .clr(clr_fall[CLR_CRC_BIT-CLR_BPV_BIT]),
        .count(crc_count), .sat(crc_sat)
    );

    pm_wrap_counter #(.W(BPV_W)) u_bpv_cnt (
        .clk(clk), .rst_n(rst_n), .inc(bpv_pulse),
        .clr(clr_fall[0]),
        .count(bpv_count), .sat(bpv_sat)
    );

    pm_wrap_counter #(.W(FE_W)) u_fe_cnt (
        .clk(clk), .rst_n(rst_n), .inc(fe_pulse),
        .clr(clr_fall[CLR_FE_BIT-CLR_BPV_BIT]),
        .count(fe_count), .sat(fe_sat)
    );

    pm_event_flag u_sef_flag (
        .clk(clk), .rst_n(rst_n), .set(tog_evt[1]),
        .clr(clr_fall[CLR_SEF_BIT-CLR_BPV_BIT]),
        .hold_clr(!ctrl_word[IRQ_EN_BIT]),
        .flag(sef_flag)
    );

    // Assemble the status byte from flags and pass-through alarms.
    always_comb begin
        status                           = '0;
        status[ST_AIS]                   = ais_in;
        status[ST_BPV_SAT]               = bpv_sat;
        status[ST_CRC_SAT]               = crc_sat;
        status[ST_FE_SAT]                = fe_sat;
        status[ST_SEF_EVT]               = sef_flag;
        status[ST_EXT_LO +: EXT_W]       = ext_stat;
    end

    assign crc_valid = esf_mode;
endmodule

// File: rtl/pm_counter_bank_chk.sv
// Checker: temporal properties of the counter bank, observed at its ports.
module pm_counter_bank_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bpv_pulse,
    input logic       fe_pulse,
    input logic [7:0] ctrl_word,
    input logic [7:0] crc_count,
    input logic [7:0] bpv_count,
    input logic [3:0] fe_count,
    input logic [7:0] status
);
    AST_CRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_count != $past(crc_count)) |->
        (crc_count == $past(crc_count) + 8'd1 || crc_count == 8'd0)); // R1
    AST_BPV_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (bpv_pulse && ctrl_word[4]) |=> (bpv_count == $past(bpv_count) + 8'd1)); // R2
    AST_FE_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_pulse && ctrl_word[6]) |=> (fe_count == $past(fe_count) + 4'd1)); // R3
    AST_CRC_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] && ctrl_word[5]) |=> status[2]); // R4
    AST_BPV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(ctrl_word[4])) |=> (bpv_count == 8'd0 && !status[1])); // R5
    AST_SEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_word[0] |=> !status[4]); // R7
    AST_CRC_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(ctrl_word[5])) |=> (crc_count == 8'd0 && !status[2])); // R8
endmodule

bind pm_counter_bank pm_counter_bank_chk u_chk (.*);

// File: tb/pm_counter_bank_tb.sv
module pm_counter_bank_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       crc_lsb_in = 1'b0, sef_lsb_in = 1'b0, bpv_pulse = 1'b0, fe_pulse = 1'b0;
    logic [7:0] ctrl_word = 8'hF1;
    logic       esf_mode = 1'b0, ais_in = 1'b0;
    logic [2:0] ext_stat = 3'b000;
    logic [7:0] crc_count, bpv_count, status;
    logic [3:0] fe_count;
    logic       crc_valid;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    pm_counter_bank u_dut (
        .clk(clk), .rst_n(rst_n), .crc_lsb_in(crc_lsb_in), .sef_lsb_in(sef_lsb_in),
        .bpv_pulse(bpv_pulse), .fe_pulse(fe_pulse), .ctrl_word(ctrl_word),
        .esf_mode(esf_mode), .ais_in(ais_in), .ext_stat(ext_stat),
        .crc_count(crc_count), .bpv_count(bpv_count), .fe_count(fe_count),
        .status(status), .crc_valid(crc_valid)
    );

    typedef struct packed {
        logic       c, b, f, s;
        logic [7:0] ctl;
        logic [7:0] ec, eb;
        logic [3:0] ef;
        logic [4:0] es;
    } vec_t;

    localparam vec_t TBL [9] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'hF1, 8'd1, 8'd0, 4'd0, 5'h00},
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'hF1, 8'd1, 8'd1, 4'd0, 5'h00},
        '{1'b0, 1'b1, 1'b1, 1'b0, 8'hF1, 8'd2, 8'd2, 4'd1, 5'h00},
        '{1'b0, 1'b0, 1'b0, 1'b1, 8'hF1, 8'd2, 8'd2, 4'd1, 5'h10},
        '{1'b0, 1'b0, 1'b0, 1'b1, 8'h71, 8'd2, 8'd2, 4'd1, 5'h00},
        '{1'b0, 1'b0, 1'b0, 1'b1, 8'h61, 8'd2, 8'd0, 4'd1, 5'h00},
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'h41, 8'd0, 8'd0, 4'd1, 5'h00},
        '{1'b1, 1'b0, 1'b1, 1'b1, 8'h01, 8'd0, 8'd0, 4'd0, 5'h00},
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'hF1, 8'd1, 8'd1, 4'd0, 5'h00}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_bpv();
        bpv_pulse = 1'b1; step(); bpv_pulse = 1'b0;
    endtask

    task automatic pulse_fe();
        fe_pulse = 1'b1; step(); fe_pulse = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk); step(); step();
        rst_n = 1'b1;
        step();
        // R10: reset state
        check("R10 crc after reset", crc_count, 0);
        check("R10 bpv after reset", bpv_count, 0);
        check("R10 status after reset", status, 0);

        // Vector table: R1 R2 R3 R5 R6 R8
        foreach (TBL[i]) begin
            crc_lsb_in = TBL[i].c; bpv_pulse = TBL[i].b;
            fe_pulse = TBL[i].f; sef_lsb_in = TBL[i].s; ctrl_word = TBL[i].ctl;
            step();
            check($sformatf("R1 crc row %0d", i), crc_count, TBL[i].ec);
            check($sformatf("R2 bpv row %0d", i), bpv_count, TBL[i].eb);
            check($sformatf("R3 fe row %0d", i), fe_count, TBL[i].ef);
            check($sformatf("R6 status row %0d", i), status[4:0], TBL[i].es);
        end
        bpv_pulse = 1'b0; fe_pulse = 1'b0;

        // CRC wrap and sticky flag (R4), falling-edge clear only (R5)
        ctrl_word[5] = 1'b0; step(); ctrl_word[5] = 1'b1; step();
        for (int k = 0; k < 255; k++) begin crc_lsb_in = ~crc_lsb_in; step(); end
        check("R1 crc at 255", crc_count, 255);
        check("R4 crc flag before wrap", status[2], 0);
        crc_lsb_in = ~crc_lsb_in; step();
        check("R4 crc wrap to 0", crc_count, 0);
        check("R4 crc flag set", status[2], 1);
        crc_lsb_in = ~crc_lsb_in; step();
        check("R4 crc flag sticky", status[2], 1);
        ctrl_word[5] = 1'b0; step();
        check("R5 crc cleared", crc_count, 0);
        check("R5 crc flag cleared", status[2], 0);
        crc_lsb_in = ~crc_lsb_in; step();
        check("R5 low level no clear", crc_count, 1);
        ctrl_word[5] = 1'b1; step();
        check("R5 rising no effect", crc_count, 1);

        // BPV: wrap colliding with clear (R8), then wrap (R4)
        ctrl_word[4] = 1'b0; step(); ctrl_word[4] = 1'b1; step();
        for (int k = 0; k < 255; k++) pulse_bpv();
        check("R2 bpv at 255", bpv_count, 255);
        bpv_pulse = 1'b1; ctrl_word[4] = 1'b0; step(); bpv_pulse = 1'b0;
        check("R8 bpv clear beats wrap", bpv_count, 0);
        check("R8 bpv flag not set", status[1], 0);
        ctrl_word[4] = 1'b1; step();
        for (int k = 0; k < 256; k++) pulse_bpv();
        check("R4 bpv wrap", bpv_count, 0);
        check("R4 bpv flag", status[1], 1);

        // FE wrap (R4) and continued counting (R3)
        ctrl_word[6] = 1'b0; step(); ctrl_word[6] = 1'b1; step();
        for (int k = 0; k < 16; k++) pulse_fe();
        check("R4 fe wrap", fe_count, 0);
        check("R4 fe flag", status[3], 1);
        pulse_fe();
        check("R3 fe after wrap", fe_count, 1);
        check("R4 fe flag sticky", status[3], 1);

        // Event flag and interrupt enable (R6 R7 R8)
        ctrl_word[0] = 1'b0; sef_lsb_in = ~sef_lsb_in; step();
        check("R7 held clear on toggle", status[4], 0);
        ctrl_word[0] = 1'b1; step();
        check("R7 enable does not set", status[4], 0);
        sef_lsb_in = ~sef_lsb_in; step();
        check("R6 set on toggle", status[4], 1);
        ctrl_word[0] = 1'b0; step();
        check("R7 enable low clears", status[4], 0);
        ctrl_word[0] = 1'b1; sef_lsb_in = ~sef_lsb_in; ctrl_word[7] = 1'b0; step();
        check("R8 clear beats set", status[4], 0);
        ctrl_word[7] = 1'b1; step();

        // Pass-through fields (R9)
        ext_stat = 3'b101; ais_in = 1'b1; esf_mode = 1'b1; #1;
        check("R9 ext bits", status[7:5], 5);
        check("R9 ais bit", status[0], 1);
        check("R9 crc_valid high", crc_valid, 1);
        esf_mode = 1'b0; #1;
        check("R9 crc_valid low", crc_valid, 0);

        // Arming after reset (R10)
        rst_n = 1'b0; crc_lsb_in = 1'b0; sef_lsb_in = 1'b0; step(); step();
        check("R10 counts zero in reset", crc_count + bpv_count + fe_count, 0);
        rst_n = 1'b1; crc_lsb_in = 1'b1; step(); step();
        check("R10 first sample not counted", crc_count, 0);
        crc_lsb_in = 1'b0; step();
        check("R1 count after arming", crc_count, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule